// File: doc/BRIEF.md
# Register Scoreboard Wakeup Tracker

This block follows which physical registers of an out-of-order core hold valid results, and tells each slot of the issue window when its source operands can be read. It keeps one ready bit per physical register. It also keeps a dependents matrix, which records for each register which window slots are waiting on it and in which operand position.

When an instruction is dispatched into a slot, each of its two sources is resolved in that same cycle. A source counts as ready if rename flagged it ready, if its tag lies beyond the physical range, if the scoreboard already shows the register ready, or if a completion for that tag arrives in the same cycle. Any source that is still unresolved sets a bit in the matrix.

Completions arrive on two ports. Each completion wakes every recorded waiter of its tag, clears that row of the matrix and sets the register's ready bit. A squash carries a sequence number, and every occupied slot whose number is larger is dropped.

Each slot is a three-state machine:

- **IDLE**: the slot is empty.
- **WAIT**: at least one operand is still missing.
- **READY**: both operands are present.

The transitions are:

- **dispatch-all-ready**: IDLE, WAIT or READY goes to READY.
- **dispatch-pending**: any state goes to WAIT.
- **last-wake**: WAIT goes to READY.
- **kill**: WAIT or READY goes to IDLE on a squash.

A one-cycle pulse marks every entry into READY.

Top module: `sbw_top`

## Requirements
- R1: After reset every register reads not ready, every slot is IDLE with both operand-ready outputs low, and no slot pulse or producer error is raised.
- R2: A dispatch with a valid destination tag below NUM_PREGS clears that register's ready bit. A later source on that tag, flagged not ready, then waits.
- R3: A source flagged ready at rename is reported ready one cycle after dispatch, whatever the scoreboard holds.
- R4: A source flagged not ready whose register is already ready in the scoreboard is reported ready one cycle after dispatch and records no dependency.
- R5: A completion of tag T sets T's ready bit and marks ready, one cycle later, every operand recorded as waiting on T, in either operand position.
- R6: Two completions on distinct tags in the same cycle both take effect in that cycle.
- R7: The slot-ready pulse is high for exactly one cycle, one cycle after the slot's last missing operand becomes available (by wakeup, or at dispatch when both sources resolve). A wakeup that leaves an operand missing gives no pulse.
- R8: Tags greater than or equal to NUM_PREGS are never tracked. Such a source is ready at once, and such a destination leaves every ready bit unchanged.
- R9: When a dispatch and a completion name the same tag in one cycle, the completion wins and the new source is ready one cycle later.
- R10: A dispatch whose destination tag still has recorded waiters, with no completion of that tag in the same cycle, raises producer_err for one cycle, on the cycle after.
- R11: A squash with sequence S moves every occupied slot whose stored sequence exceeds S to IDLE. Its operand-ready outputs drop, and later completions give it no wakeup or pulse. Slots with sequence up to S keep waiting.
- R12: A completion empties its tag's waiter row in the same cycle, so a new producer of that tag dispatched afterwards raises no producer_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_entry | input | ENT_W | Window slot being written |
| disp_seq | input | SEQ_W | Age of the dispatched instruction |
| disp_src0_tag | input | TAG_W | First source register |
| disp_src0_rdy | input | 1 | First source ready at rename |
| disp_src1_tag | input | TAG_W | Second source register |
| disp_src1_rdy | input | 1 | Second source ready at rename |
| disp_dst_valid | input | 1 | Instruction writes a register |
| disp_dst_tag | input | TAG_W | Destination register |
| cmp0_valid | input | 1 | Completion port 0 strobe |
| cmp0_tag | input | TAG_W | Completion port 0 register |
| cmp1_valid | input | 1 | Completion port 1 strobe |
| cmp1_tag | input | TAG_W | Completion port 1 register |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Slots younger than this are dropped |
| op0_rdy | output | NUM_ENTRIES | Per-slot first operand ready |
| op1_rdy | output | NUM_ENTRIES | Per-slot second operand ready |
| entry_woke | output | NUM_ENTRIES | Per-slot one-cycle became-ready pulse |
| producer_err | output | 1 | New producer set on a register with waiters |

## Verification
Dispatch and completion can name the same register in one cycle. The bench provokes this by driving a completion strobe together with a dispatch whose source is that register. The source must show ready one cycle later with a slot pulse, and no waiter may remain, which a following producer dispatch confirms by raising no producer error. A squash can also meet a completion. The bench drops a younger slot and then completes its register, and it expects no pulse for the dropped slot while an older waiter on the same register wakes.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/sbw_ready_bits.sv
module sbw_ready_bits #(
    parameter int NUM_PREGS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PREGS-1:0] set_vec,
    input  logic [NUM_PREGS-1:0] clr_vec,
    output logic [NUM_PREGS-1:0] ready
);
    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          ready[r] <= 1'b0;
            else if (clr_vec[r]) ready[r] <= 1'b0;
            else if (set_vec[r]) ready[r] <= 1'b1;
        end

        // R5
        cmp_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[r] && !clr_vec[r]) |=> ready[r]);
        // R2
        dst_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[r] |=> !ready[r]);
    end
endmodule

// File: rtl/sbw_dep_matrix.sv
module sbw_dep_matrix #(
    parameter int NUM_PREGS   = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PREGS-1:0]   row_clr,
    input  logic [NUM_ENTRIES-1:0] col_clr,
    input  logic [NUM_ENTRIES-1:0] disp_oh,
    input  logic [NUM_PREGS-1:0]   need0,
    input  logic [NUM_PREGS-1:0]   need1,
    input  logic [NUM_PREGS-1:0]   dst_oh,
    output logic [NUM_ENTRIES-1:0] wake0,
    output logic [NUM_ENTRIES-1:0] wake1,
    output logic                   producer_err
);
    logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] dep0_q;
    logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] dep1_q;
    logic [NUM_PREGS-1:0]                  row_busy;

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_row
        assign row_busy[r] = |dep0_q[r] || |dep1_q[r];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dep0_q[r] <= '0;
                dep1_q[r] <= '0;
            end else if (row_clr[r]) begin
                dep0_q[r] <= '0;
                dep1_q[r] <= '0;
            end else begin
                dep0_q[r] <= (dep0_q[r] & ~col_clr) | (disp_oh & {NUM_ENTRIES{need0[r]}});
                dep1_q[r] <= (dep1_q[r] & ~col_clr) | (disp_oh & {NUM_ENTRIES{need1[r]}});
            end
        end

        // R12
        row_empty_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (row_clr[r] && !need0[r] && !need1[r]) |=> !row_busy[r]);
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_col
        always_comb begin
            wake0[e] = 1'b0;
            wake1[e] = 1'b0;
            for (int r = 0; r < NUM_PREGS; r++) begin
                wake0[e] = wake0[e] | (dep0_q[r][e] & row_clr[r]);
                wake1[e] = wake1[e] | (dep1_q[r][e] & row_clr[r]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) producer_err <= 1'b0;
        else        producer_err <= |(dst_oh & row_busy & ~row_clr);
    end

    // R10
    err_needs_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        producer_err |-> $past(|dst_oh));
endmodule

// File: rtl/sbw_slot.sv
module sbw_slot
    import sbw_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_here,
    input  logic             rdy0_in,
    input  logic             rdy1_in,
    input  logic [SEQ_W-1:0] disp_seq,
    input  logic             wake0,
    input  logic             wake1,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             kill,
    output logic             op0_rdy,
    output logic             op1_rdy,
    output logic             woke
);
    slot_state_e      st_q, st_d;
    logic [SEQ_W-1:0] seq_q;
    logic             op0_d, op1_d, woke_d;

    assign kill = squash_valid && !disp_here && (st_q != SLOT_IDLE) && (seq_q > squash_seq);

    always_comb begin
        st_d   = st_q;
        op0_d  = op0_rdy;
        op1_d  = op1_rdy;
        woke_d = 1'b0;
        if (disp_here) begin
            op0_d  = rdy0_in;
            op1_d  = rdy1_in;
            woke_d = rdy0_in && rdy1_in;
            st_d   = woke_d ? SLOT_READY : SLOT_WAIT;
        end else if (kill) begin
            op0_d = 1'b0;
            op1_d = 1'b0;
            st_d  = SLOT_IDLE;
        end else begin
            unique case (st_q)
                SLOT_IDLE:  st_d = SLOT_IDLE;
                SLOT_WAIT: begin
                    op0_d = op0_rdy | wake0;
                    op1_d = op1_rdy | wake1;
                    if (op0_d && op1_d) begin
                        st_d   = SLOT_READY;
                        woke_d = 1'b1;
                    end
                end
                SLOT_READY: st_d = SLOT_READY;
                default:    st_d = SLOT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SLOT_IDLE;
            seq_q <= '0;
        end else begin
            st_q <= st_d;
            if (disp_here) seq_q <= disp_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op0_rdy <= 1'b0;
            op1_rdy <= 1'b0;
            woke    <= 1'b0;
        end else begin
            op0_rdy <= op0_d;
            op1_rdy <= op1_d;
            woke    <= woke_d;
        end
    end

    // R7
    pulse_both_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        woke |-> (op0_rdy && op1_rdy));
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (woke && !disp_here) |=> !woke);
    // R11
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!op0_rdy && !op1_rdy && !woke));
    // R5
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op0_rdy && !disp_here && !kill) |=> op0_rdy);
endmodule

// File: rtl/sbw_top.sv
module sbw_top #(
    parameter int NUM_PREGS   = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int TAG_W       = 6,
    parameter int SEQ_W       = 8,
    localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [ENT_W-1:0]       disp_entry,
    input  logic [SEQ_W-1:0]       disp_seq,
    input  logic [TAG_W-1:0]       disp_src0_tag,
    input  logic                   disp_src0_rdy,
    input  logic [TAG_W-1:0]       disp_src1_tag,
    input  logic                   disp_src1_rdy,
    input  logic                   disp_dst_valid,
    input  logic [TAG_W-1:0]       disp_dst_tag,
    input  logic                   cmp0_valid,
    input  logic [TAG_W-1:0]       cmp0_tag,
    input  logic                   cmp1_valid,
    input  logic [TAG_W-1:0]       cmp1_tag,
    input  logic                   squash_valid,
    input  logic [SEQ_W-1:0]       squash_seq,
    output logic [NUM_ENTRIES-1:0] op0_rdy,
    output logic [NUM_ENTRIES-1:0] op1_rdy,
    output logic [NUM_ENTRIES-1:0] entry_woke,
    output logic                   producer_err
);
    localparam logic [TAG_W:0] NP_LIM = (TAG_W+1)'(NUM_PREGS);

    logic [NUM_PREGS-1:0]   cmp_hit, dst_oh, src0_oh, src1_oh, need0, need1, sb_ready;
    logic [NUM_ENTRIES-1:0] disp_oh, kill_vec, wake0, wake1;
    logic                   in0, in1, now0, now1;

    assign in0 = {1'b0, disp_src0_tag} < NP_LIM;
    assign in1 = {1'b0, disp_src1_tag} < NP_LIM;

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_dec
        localparam logic [TAG_W-1:0] RT = TAG_W'(r);
        assign cmp_hit[r] = (cmp0_valid && cmp0_tag == RT) || (cmp1_valid && cmp1_tag == RT);
        assign dst_oh[r]  = disp_valid && disp_dst_valid && disp_dst_tag == RT;
        assign src0_oh[r] = disp_src0_tag == RT;
        assign src1_oh[r] = disp_src1_tag == RT;
    end

    assign now0  = disp_src0_rdy || !in0 || |(src0_oh & (sb_ready | cmp_hit));
    assign now1  = disp_src1_rdy || !in1 || |(src1_oh & (sb_ready | cmp_hit));
    assign need0 = src0_oh & {NUM_PREGS{disp_valid && !now0}};
    assign need1 = src1_oh & {NUM_PREGS{disp_valid && !now1}};

    sbw_ready_bits #(.NUM_PREGS(NUM_PREGS)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cmp_hit),
        .clr_vec (dst_oh),
        .ready   (sb_ready)
    );

    sbw_dep_matrix #(.NUM_PREGS(NUM_PREGS), .NUM_ENTRIES(NUM_ENTRIES)) u_deps (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_clr      (cmp_hit),
        .col_clr      (disp_oh | kill_vec),
        .disp_oh      (disp_oh),
        .need0        (need0),
        .need1        (need1),
        .dst_oh       (dst_oh),
        .wake0        (wake0),
        .wake1        (wake1),
        .producer_err (producer_err)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        assign disp_oh[e] = disp_valid && disp_entry == ENT_W'(e);

        sbw_slot #(.SEQ_W(SEQ_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .disp_here    (disp_oh[e]),
            .rdy0_in      (now0),
            .rdy1_in      (now1),
            .disp_seq     (disp_seq),
            .wake0        (wake0[e]),
            .wake1        (wake1[e]),
            .squash_valid (squash_valid),
            .squash_seq   (squash_seq),
            .kill         (kill_vec[e]),
            .op0_rdy      (op0_rdy[e]),
            .op1_rdy      (op1_rdy[e]),
            .woke         (entry_woke[e])
        );
    end

    // R9
    same_cycle_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && in0 && |(src0_oh & cmp_hit)) |=> op0_rdy[$past(disp_entry)]);
    // R8
    out_of_range_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !in1) |=> op1_rdy[$past(disp_entry)]);
    // R3
    rename_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_src0_rdy) |=> op0_rdy[$past(disp_entry)]);
endmodule

// File: tb/tb_sbw_top.sv
module tb_sbw_top;
    localparam int NP = 8;
    localparam int NE = 4;
    localparam int TW = 4;
    localparam int SW = 4;
    localparam int OOR = NP + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid;
    logic [1:0]    disp_entry;
    logic [SW-1:0] disp_seq;
    logic [TW-1:0] disp_src0_tag, disp_src1_tag, disp_dst_tag;
    logic          disp_src0_rdy, disp_src1_rdy, disp_dst_valid;
    logic          cmp0_valid, cmp1_valid, squash_valid;
    logic [TW-1:0] cmp0_tag, cmp1_tag;
    logic [SW-1:0] squash_seq;
    logic [NE-1:0] op0_rdy, op1_rdy, entry_woke;
    logic          producer_err;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    sbw_top #(.NUM_PREGS(NP), .NUM_ENTRIES(NE), .TAG_W(TW), .SEQ_W(SW)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_entry(disp_entry), .disp_seq(disp_seq),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .disp_dst_valid(disp_dst_valid), .disp_dst_tag(disp_dst_tag),
        .cmp0_valid(cmp0_valid), .cmp0_tag(cmp0_tag),
        .cmp1_valid(cmp1_valid), .cmp1_tag(cmp1_tag),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .op0_rdy(op0_rdy), .op1_rdy(op1_rdy), .entry_woke(entry_woke),
        .producer_err(producer_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        disp_valid = 0; disp_entry = 0; disp_seq = 0;
        disp_src0_tag = 0; disp_src0_rdy = 0; disp_src1_tag = 0; disp_src1_rdy = 0;
        disp_dst_valid = 0; disp_dst_tag = 0;
        cmp0_valid = 0; cmp0_tag = 0; cmp1_valid = 0; cmp1_tag = 0;
        squash_valid = 0; squash_seq = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1 clr_in();
        @(negedge clk);
    endtask

    task automatic disp(input int e, input int seq, input int s0, input int r0,
                        input int s1, input int r1, input int dv, input int d);
        disp_valid = 1; disp_entry = 2'(e); disp_seq = SW'(seq);
        disp_src0_tag = TW'(s0); disp_src0_rdy = r0[0];
        disp_src1_tag = TW'(s1); disp_src1_rdy = r1[0];
        disp_dst_valid = dv[0]; disp_dst_tag = TW'(d);
    endtask

    task automatic cmp(input int port, input int t);
        if (port == 0) begin cmp0_valid = 1; cmp0_tag = TW'(t); end
        else           begin cmp1_valid = 1; cmp1_tag = TW'(t); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        clr_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 op0", int'(op0_rdy), 0);
        check("R1 op1", int'(op1_rdy), 0);
        check("R1 woke", int'(entry_woke), 0);
        check("R1 err", int'(producer_err), 0);
        disp(3, 0, 0, 0, 7, 0, 0, 0); tick();
        check("R1 reg0 not ready", int'(op0_rdy[3]), 0);
        check("R1 reg7 not ready", int'(op1_rdy[3]), 0);
        check("R1 no pulse", int'(entry_woke[3]), 0);
        // R6 two completions at once
        cmp(0, 0); cmp(1, 7); tick();
        check("R6 op0", int'(op0_rdy[3]), 1);
        check("R6 op1", int'(op1_rdy[3]), 1);
        check("R6 pulse", int'(entry_woke[3]), 1);
        tick();
        check("R7 pulse one cycle", int'(entry_woke[3]), 0);

        // R4 R5 R8 sweep across every tag plus out-of-range tags
        for (int t = 0; t <= NP + 1; t++) begin
            int inr;
            inr = (t < NP) ? 1 : 0;
            disp(0, 1, OOR, 1, OOR, 1, 1, t); tick();
            check("R10 no err sweep", int'(producer_err), 0);
            disp(1, 2, t, 0, OOR, 0, 0, 0); tick();
            check("R8 R2 src vs dst", int'(op0_rdy[1]), 1 - inr);
            check("R8 oor src1 ready", int'(op1_rdy[1]), 1);
            check("R7 dispatch pulse", int'(entry_woke[1]), 1 - inr);
            cmp(0, t); tick();
            check("R5 wake op0", int'(op0_rdy[1]), 1);
            check("R5 wake pulse", int'(entry_woke[1]), inr);
            disp(2, 3, t, 0, OOR, 0, 0, 0); tick();
            check("R4 scoreboard ready", int'(op0_rdy[2]), 1);
            check("R4 pulse", int'(entry_woke[2]), 1);
        end

        // R2 and R3
        disp(0, 1, OOR, 1, OOR, 1, 1, 1); tick();
        disp(1, 2, 1, 0, OOR, 1, 0, 0); tick();
        check("R2 cleared bit waits", int'(op0_rdy[1]), 0);
        disp(2, 3, 1, 1, OOR, 1, 0, 0); tick();
        check("R3 rename ready", int'(op0_rdy[2]), 1);
        cmp(1, 1); tick();
        check("R5 slot1 wake port1", int'(entry_woke[1]), 1);

        // R7 partial wake gives no pulse
        disp(0, 1, OOR, 1, OOR, 1, 1, 4); tick();
        disp(0, 1, OOR, 1, OOR, 1, 1, 5); tick();
        disp(1, 2, 4, 0, 5, 0, 0, 0); tick();
        check("R7 waits both", int'({op0_rdy[1], op1_rdy[1]}), 0);
        cmp(0, 4); tick();
        check("R7 op0 after first", int'(op0_rdy[1]), 1);
        check("R7 op1 after first", int'(op1_rdy[1]), 0);
        check("R7 no early pulse", int'(entry_woke[1]), 0);
        cmp(0, 5); tick();
        check("R7 last operand pulse", int'(entry_woke[1]), 1);
        tick();
        check("R7 pulse drops", int'(entry_woke[1]), 0);

        // R6 two completions wake different slots and positions
        disp(0, 1, OOR, 1, OOR, 1, 1, 6); tick();
        disp(0, 1, OOR, 1, OOR, 1, 1, 7); tick();
        disp(1, 2, 6, 0, OOR, 1, 0, 0); tick();
        disp(2, 3, 7, 0, OOR, 1, 0, 0); tick();
        disp(3, 4, OOR, 1, 6, 0, 0, 0); tick();
        cmp(0, 6); cmp(1, 7); tick();
        check("R6 multi wake", int'(entry_woke[3:1]), 7);
        check("R6 op1 slot3", int'(op1_rdy[3]), 1);

        // R9 same-cycle dispatch and completion, then R12
        disp(0, 1, OOR, 1, OOR, 1, 1, 2); tick();
        disp(1, 2, 2, 0, OOR, 1, 0, 0); cmp(0, 2); tick();
        check("R9 completion wins", int'(op0_rdy[1]), 1);
        check("R9 pulse", int'(entry_woke[1]), 1);
        disp(0, 1, OOR, 1, OOR, 1, 1, 2); tick();
        check("R12 no stale waiter", int'(producer_err), 0);
        cmp(0, 2); tick();

        // R10 producer error
        disp(0, 1, OOR, 1, OOR, 1, 1, 3); tick();
        disp(1, 2, 3, 0, OOR, 1, 0, 0); tick();
        disp(2, 3, OOR, 1, OOR, 1, 1, 3); tick();
        check("R10 error raised", int'(producer_err), 1);
        tick();
        check("R10 error one cycle", int'(producer_err), 0);
        cmp(0, 3); tick();
        check("R10 waiter still woken", int'(entry_woke[1]), 1);

        // R11 squash
        disp(0, 1, OOR, 1, OOR, 1, 1, 5); tick();
        disp(1, 5, 5, 0, OOR, 1, 0, 0); tick();
        disp(2, 9, 5, 0, OOR, 1, 0, 0); tick();
        disp(3, 10, OOR, 1, OOR, 1, 0, 0); tick();
        check("R11 young ready before", int'(op0_rdy[3]), 1);
        squash_valid = 1; squash_seq = SW'(6); tick();
        check("R11 young ready dropped", int'({op0_rdy[3], op1_rdy[3]}), 0);
        check("R11 older untouched", int'(op1_rdy[1]), 1);
        cmp(0, 5); tick();
        check("R11 older wakes", int'(entry_woke[1]), 1);
        check("R11 killed no pulse", int'(entry_woke[2]), 0);
        check("R11 killed op stays low", int'(op0_rdy[2]), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule